// File: doc/BRIEF.md
# Credit-Based Admission Controller for a Memory Request Tree

This block sits beside one requestor at a leaf of a tree-shaped memory network. It decides, once per scheduling interval, whether the requestor's outstanding memory request is sent up the tree. It also sets the priority that the request carries. A single signed credit register controls the decision. A reset value, a gain per active interval, a charge per grant, a level reloaded at each frame boundary, and a window of acceptable credit are all parameters. The same logic can therefore behave as a slot-based, a frame-based or a rate-based admission scheme.

A request whose credit lies inside the window goes out with an eligibility bit set above the requestor's fixed priority. A request whose credit lies outside the window still goes out, with that bit clear, so it loses to every eligible request in the tree. Idle memory time is not wasted this way. The memory side answers with a grant a fixed number of cycles after the interval strobe. A request that receives no grant stays pending and is offered again at the next interval.

Top module: `credit_admit_ni`

## Requirements
- R1: After reset, `req_vld` is 0, `prio_tag` is 0, no request is pending, and the credit equals parameter `INIT_CREDIT`.
- R2: When `iv_stb` is high on a clock edge, no grant window is open, and a request is pending, then `req_vld` rises after that edge. It stays high for exactly `GRANT_LAT` cycles and falls on the edge `GRANT_LAT` edges after the strobe (the grant edge). With nothing pending, `req_vld` stays 0.
- R3: While `req_vld` is high, `prio_tag[PRIO_W]` is the eligibility bit and `prio_tag[PRIO_W-1:0]` equals `STATIC_PRIO`. The eligibility bit is 1 exactly when `LO_BOUND <= credit <= HI_BOUND`, with the credit taken as it stood at the strobe edge. While `req_vld` is low, `prio_tag` is 0.
- R4: On the grant edge of an interval in which a request was sent, the credit becomes credit + `CREDIT_INC`, minus `CREDIT_DEC` if `gnt_in` is high on that edge. An interval without a request leaves the credit unchanged.
- R5: The credit is a signed `CREDIT_W`-bit value that clamps at -2^(CREDIT_W-1) and 2^(CREDIT_W-1)-1 instead of wrapping.
- R6: `frame_stb` high on an edge loads the credit with `REPLENISH`. This holds in any cycle, and the reload takes precedence over an update on the same edge.
- R7: A request that is not granted on its grant edge stays pending and is sent again at the next interval strobe. A grant clears it. A `req_in` pulse sets the pending flag, and a single flag holds at most one request.
- R8: An `iv_stb` that arrives while a grant window is open is ignored. A `gnt_in` outside a grant edge, or on the grant edge of an interval with no request, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iv_stb | input | 1 | Scheduling interval start strobe |
| frame_stb | input | 1 | Frame boundary strobe; reloads the credit |
| req_in | input | 1 | One-cycle pulse announcing a local request |
| gnt_in | input | 1 | Grant notification, sampled on the grant edge |
| req_vld | output | 1 | Request offered to the tree |
| prio_tag | output | PRIO_W+1 | {eligible, STATIC_PRIO} while offered, else 0 |

## Verification
The credit is not a port. Its two clamp limits are visible only through the eligibility bit on later launches, which makes saturation the hardest case to show. The bench narrows the credit and the window. A long run of ungranted retries drives the credit into the upper clamp, and a long run of granted requests drives it into the lower clamp. A bench model predicts each launch's tag, so a wrapped credit shows up as a wrong eligibility bit several intervals later. Random intervals mixed with frame reloads, stray grants and strobes inside open windows then cover the rest.

// File: rtl/credit_ni_pkg.sv
package credit_ni_pkg;

   // clamp an integer into [lo, hi]
   function automatic int clip_int(input int v, input int lo, input int hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

endpackage

// File: rtl/ni_window_timer.sv
module ni_window_timer #(
   parameter int GRANT_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic iv_stb,
   output logic start,
   output logic close_now,
   output logic win_open
);
   localparam int CNT_W = (GRANT_LAT < 2) ? 1 : $clog2(GRANT_LAT);

   logic [CNT_W-1:0] cnt_q;
   logic             open_q;

   assign start     = iv_stb & ~open_q;
   assign close_now = open_q & (cnt_q == '0);
   assign win_open  = open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         open_q <= 1'b1;
         cnt_q  <= CNT_W'(GRANT_LAT - 1);
      end else if (open_q) begin
         if (cnt_q == '0) open_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R8: a strobe inside an open window never restarts it
   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !close_now) |=> (open_q && cnt_q == $past(cnt_q) - 1'b1));

   // R2: an accepted strobe always opens the window
   p_open_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> open_q);

endmodule

// File: rtl/ni_credit_engine.sv
module ni_credit_engine
   import credit_ni_pkg::*;
#(
   parameter int CREDIT_W    = 8,
   parameter int INIT_CREDIT = 4,
   parameter int CREDIT_INC  = 1,
   parameter int CREDIT_DEC  = 3,
   parameter int REPLENISH   = 4,
   parameter int LO_BOUND    = 3,
   parameter int HI_BOUND    = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic granted,
   input  logic frame_stb,
   output logic eligible
);
   localparam int MAX_C = (1 << (CREDIT_W - 1)) - 1;
   localparam int MIN_C = -(1 << (CREDIT_W - 1));
   localparam bit OPEN_WINDOW = (LO_BOUND <= MIN_C) && (HI_BOUND >= MAX_C);

   logic signed [CREDIT_W-1:0] credit_q;
   int sum_i;
   int nxt_i;

   always_comb begin
      sum_i = int'(credit_q) + CREDIT_INC - (granted ? CREDIT_DEC : 0);
      nxt_i = clip_int(sum_i, MIN_C, MAX_C);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         credit_q <= CREDIT_W'(INIT_CREDIT);
      else if (frame_stb) credit_q <= CREDIT_W'(REPLENISH);
      else if (upd)       credit_q <= CREDIT_W'(nxt_i);
   end

   generate
      if (OPEN_WINDOW) begin : g_open
         assign eligible = 1'b1;
      end else begin : g_bounded
         assign eligible = (int'(credit_q) >= LO_BOUND) &&
                           (int'(credit_q) <= HI_BOUND);
      end
   endgenerate

   // R5: with no charge the credit never falls (no wrap past the top)
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !granted && !frame_stb) |=> (credit_q >= $past(credit_q)));

   // R5: a charge never raises the credit above its old value plus gain
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && granted && !frame_stb) |=>
      (int'(credit_q) <= int'($past(credit_q)) + CREDIT_INC));

   // R6: frame reload wins over everything
   p_frame_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> (int'(credit_q) == REPLENISH));

   // R4: idle intervals leave the credit alone
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !frame_stb) |=> $stable(credit_q));

endmodule

// File: rtl/ni_request_tracker.sv
module ni_request_tracker #(
   parameter int PRIO_W      = 3,
   parameter int STATIC_PRIO = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_in,
   input  logic              start,
   input  logic              close_now,
   input  logic              gnt_in,
   input  logic              eligible,
   output logic              upd,
   output logic              granted,
   output logic              req_vld,
   output logic [PRIO_W:0]   prio_tag
);
   logic pend_q;

   assign upd     = close_now & req_vld;
   assign granted = upd & gnt_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         req_vld  <= 1'b0;
         prio_tag <= '0;
      end else begin
         pend_q <= req_in | (pend_q & ~granted);
         if (start && pend_q) begin
            req_vld  <= 1'b1;
            prio_tag <= {eligible, PRIO_W'(STATIC_PRIO)};
         end else if (close_now) begin
            req_vld  <= 1'b0;
            prio_tag <= '0;
         end
      end
   end

   // R2: a pending request is launched on an accepted strobe
   p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && pend_q) |=> req_vld);

   // R3: tag is frozen while the request is offered
   p_tag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !close_now) |=> (req_vld && $stable(prio_tag)));

   // R7: an ungranted request survives for the next interval
   p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !gnt_in) |=> pend_q);

   // R8: a stray grant cannot clear the pending flag
   p_stray_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !upd) |=> pend_q);

endmodule

// File: rtl/credit_admit_ni.sv
module credit_admit_ni #(
   parameter int CREDIT_W    = 8,
   parameter int INIT_CREDIT = 4,
   parameter int CREDIT_INC  = 1,
   parameter int CREDIT_DEC  = 3,
   parameter int REPLENISH   = 4,
   parameter int LO_BOUND    = 3,
   parameter int HI_BOUND    = 100,
   parameter int PRIO_W      = 3,
   parameter int STATIC_PRIO = 5,
   parameter int GRANT_LAT   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iv_stb,
   input  logic            frame_stb,
   input  logic            req_in,
   input  logic            gnt_in,
   output logic            req_vld,
   output logic [PRIO_W:0] prio_tag
);
   localparam int MAX_C = (1 << (CREDIT_W - 1)) - 1;
   localparam int MIN_C = -(1 << (CREDIT_W - 1));

   if (CREDIT_W < 2 || CREDIT_W > 30) begin : g_bad_width
      $error("CREDIT_W out of range");
   end
   if (GRANT_LAT < 1) begin : g_bad_lat
      $error("GRANT_LAT must be at least 1");
   end
   if (CREDIT_INC < 0 || CREDIT_INC > MAX_C || CREDIT_DEC < 0 || CREDIT_DEC > MAX_C) begin : g_bad_step
      $error("credit steps must be non-negative and fit the credit width");
   end
   if (INIT_CREDIT < MIN_C || INIT_CREDIT > MAX_C || REPLENISH < MIN_C || REPLENISH > MAX_C) begin : g_bad_load
      $error("load values must fit the credit width");
   end
   if (LO_BOUND > HI_BOUND) begin : g_bad_bounds
      $error("LO_BOUND above HI_BOUND");
   end
   if (PRIO_W < 1 || STATIC_PRIO < 0 || STATIC_PRIO >= (1 << PRIO_W)) begin : g_bad_prio
      $error("STATIC_PRIO does not fit PRIO_W");
   end

   logic start, close_now, win_open;
   logic upd, granted, eligible;

   ni_window_timer #(.GRANT_LAT(GRANT_LAT)) u_timer (
      .clk(clk), .rst_n(rst_n), .iv_stb(iv_stb),
      .start(start), .close_now(close_now), .win_open(win_open)
   );

   ni_credit_engine #(
      .CREDIT_W(CREDIT_W), .INIT_CREDIT(INIT_CREDIT), .CREDIT_INC(CREDIT_INC),
      .CREDIT_DEC(CREDIT_DEC), .REPLENISH(REPLENISH),
      .LO_BOUND(LO_BOUND), .HI_BOUND(HI_BOUND)
   ) u_credit (
      .clk(clk), .rst_n(rst_n), .upd(upd), .granted(granted),
      .frame_stb(frame_stb), .eligible(eligible)
   );

   ni_request_tracker #(.PRIO_W(PRIO_W), .STATIC_PRIO(STATIC_PRIO)) u_track (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .start(start),
      .close_now(close_now), .gnt_in(gnt_in), .eligible(eligible),
      .upd(upd), .granted(granted), .req_vld(req_vld), .prio_tag(prio_tag)
   );

   // R2: the request is only offered inside a grant window
   p_vld_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |-> win_open);

   // R3: an idle output carries a zero tag
   p_idle_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |-> (prio_tag == '0));

endmodule

// File: tb/credit_admit_ni_test.sv
module credit_admit_ni_test;
   localparam int CLK_PERIOD = 10;
   localparam int CW   = 5;
   localparam int INIT = 2;
   localparam int INC  = 3;
   localparam int DEC  = 5;
   localparam int REPL = 6;
   localparam int LO   = 4;
   localparam int HI   = 13;
   localparam int PW   = 3;
   localparam int SP   = 5;
   localparam int LAT  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iv_stb = 1'b0, frame_stb = 1'b0, req_in = 1'b0, gnt_in = 1'b0;
   logic req_vld;
   logic [PW:0] prio_tag;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int  m_credit;
   bit  m_pend;

   always #(CLK_PERIOD/2) clk = ~clk;

   credit_admit_ni #(
      .CREDIT_W(CW), .INIT_CREDIT(INIT), .CREDIT_INC(INC), .CREDIT_DEC(DEC),
      .REPLENISH(REPL), .LO_BOUND(LO), .HI_BOUND(HI), .PRIO_W(PW),
      .STATIC_PRIO(SP), .GRANT_LAT(LAT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .iv_stb(iv_stb), .frame_stb(frame_stb),
      .req_in(req_in), .gnt_in(gnt_in), .req_vld(req_vld), .prio_tag(prio_tag)
   );

   function automatic int sat(input int v);
      if (v > (1 << (CW-1)) - 1) return (1 << (CW-1)) - 1;
      if (v < -(1 << (CW-1)))    return -(1 << (CW-1));
      return v;
   endfunction

   function automatic logic [PW:0] exp_tag(input int c, input bit p);
      if (!p) return '0;
      return {((c >= LO) && (c <= HI)), PW'(SP)};
   endfunction

   task automatic check(input string lbl, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", lbl, act, expv);
      end
   endtask

   // one idle cycle with optional request, frame or stray grant
   task automatic idle(input bit r, input bit f, input bit g);
      @(negedge clk);
      req_in = r; frame_stb = f; gnt_in = g;
      @(negedge clk);
      req_in = 0; frame_stb = 0; gnt_in = 0;
      if (f) m_credit = REPL;
      if (r) m_pend = 1;
      check(g ? "R8 stray grant vld" : "R2 idle vld", {31'd0, req_vld}, 32'd0);
   endtask

   // one scheduling interval; lbl names the requirement the tag check covers
   task automatic interval(input bit g, input bit f, input bit mid, input string lbl);
      logic [PW:0] et;
      bit ev;
      @(negedge clk);
      iv_stb = 1;
      @(negedge clk);
      iv_stb = 0;
      et = exp_tag(m_credit, m_pend);
      ev = m_pend;
      check({lbl, " tag"}, {28'd0, prio_tag}, {28'd0, et});
      check("R2 launch vld", {31'd0, req_vld}, {31'd0, ev});
      if (mid) iv_stb = 1;
      for (int k = 1; k < LAT; k++) begin
         @(negedge clk);
         iv_stb = 0;
         check("R2 vld held", {31'd0, req_vld}, {31'd0, ev});
      end
      gnt_in = g; frame_stb = f;
      @(negedge clk);
      gnt_in = 0; frame_stb = 0;
      check(mid ? "R8 mid strobe ignored" : "R2 vld falls", {31'd0, req_vld}, 32'd0);
      if (ev) begin
         m_credit = sat(m_credit + INC - (g ? DEC : 0));
         if (g) m_pend = 0;
      end
      if (f) m_credit = REPL;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      m_credit = INIT; m_pend = 0;
      repeat (3) @(negedge clk);
      check("R1 reset vld", {31'd0, req_vld}, 32'd0);
      check("R1 reset tag", {28'd0, prio_tag}, 32'd0);
      rst_n = 1;
      // nothing pending: strobe launches nothing
      interval(1'b1, 1'b0, 1'b0, "R1 no pending");
      // first launch shows reset credit (2 is below window)
      idle(1'b1, 1'b0, 1'b0);
      interval(1'b0, 1'b0, 1'b0, "R1 init credit");
      // retries without grant climb the credit: 5,8,11,14,15
      for (int i = 0; i < 4; i++) interval(1'b0, 1'b0, 1'b0, "R7 retry R4 gain");
      for (int i = 0; i < 3; i++) interval(1'b0, 1'b0, 1'b0, "R5 top clamp");
      // strobe inside open window
      interval(1'b0, 1'b0, 1'b1, "R8 mid strobe");
      // granted requests drive credit down into the bottom clamp
      for (int i = 0; i < 20; i++) begin
         interval(1'b1, 1'b0, 1'b0, "R5 bottom clamp R4 charge");
         idle(1'b1, 1'b0, 1'b0);
      end
      // climb back out of the clamp without grants
      for (int i = 0; i < 8; i++) interval(1'b0, 1'b0, 1'b0, "R5 leave clamp");
      // stray grant with request pending outside window
      idle(1'b0, 1'b0, 1'b1);
      interval(1'b0, 1'b0, 1'b0, "R8 stray grant kept pending");
      // frame reload on the grant edge overrides the update
      interval(1'b1, 1'b1, 1'b0, "R6 frame on grant edge");
      idle(1'b1, 1'b0, 1'b0);
      interval(1'b0, 1'b0, 1'b0, "R6 after reload");
      idle(1'b0, 1'b1, 1'b0);
      interval(1'b1, 1'b0, 1'b0, "R6 idle frame");
      // random mix
      for (int i = 0; i < 400; i++) begin
         int r;
         r = int'($urandom % 8);
         if (r == 0) idle(1'b0, 1'b1, 1'b0);
         else if (r == 1) idle(1'b0, 1'b0, 1'b1);
         if ($urandom % 3 != 0) idle(1'b1, 1'b0, 1'b0);
         interval(1'($urandom % 2), ($urandom % 10) == 0, ($urandom % 6) == 0, "R3 R4 random");
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule